// File: doc/BRIEF.md
# Bus Cycle Length and Timer Tick Generator

This block sets the length of each bus cycle of a small audio coprocessor, counted in clocks of a fast master clock. A configuration byte holds two 2-bit divider selects. One applies to external accesses, which are RAM reads and writes that pass through the companion sound chip. The other applies to internal accesses: boot ROM, I/O registers and idle cycles. The CPU core raises `access_start` together with `access_type` when a cycle begins. The block then raises `cycle_done` for exactly one master clock, on the last clock of that cycle.

The master clock divided by `BASE_DIV` (12 by default, so 24.576 MHz becomes 2.048 MHz) is the nominal coprocessor rate. Lengths are counted in units of `2*BASE_DIV` master clocks. With the anomaly variant enabled, the CPU cycle for selects 0, 1, 2 and 3 lasts 1, 2, 5 and 10 units. The two slow settings therefore stretch to odd lengths, but every cycle still ends after a fixed count.

A free-running timer tick is kept apart from the CPU cycle. Its period is always 1, 2, 4 or 8 units, taken from the internal select, and it does not depend on whether an access is in progress.

Top module: `bus_cycle_timer`

## Requirements
- R1: A synchronous reset clears both selects to 0 and clears all counters. After reset, accesses of either type last 1 unit (24 clocks). The first timer tick comes on the 24th clock after reset is released.
- R2: With the anomaly variant, a cycle lasts 24, 48, 120 or 240 master clocks for select values 0, 1, 2 and 3.
- R3: `access_type`=1 uses the external select held in configuration bits 5:4. `access_type`=0 uses the internal select held in bits 7:6.
- R4: `cycle_done` is high for a single clock, on the L-th clock of a cycle of length L. The clock in which `access_start` is sampled counts as the first clock.
- R5: A cycle's length is fixed by the selects stored when it starts. A configuration write during the cycle affects only later cycles.
- R6: `cycle_done` never rises while no cycle is pending. An `access_start` during a running cycle, other than in its final clock, is ignored.
- R7: An `access_start` in the same clock as `cycle_done` begins the next cycle at once, with no idle clock between.
- R8: `timer_tick` pulses once every 24·2^s master clocks, where s is the internal select. This holds whether or not accesses are running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte (bits 5:4 external select, bits 7:6 internal select) |
| access_start | input | 1 | One-clock pulse that begins a bus cycle |
| access_type | input | 1 | 1 = external RAM access, 0 = internal or idle |
| cycle_done | output | 1 | High on the last master clock of the cycle |
| timer_tick | output | 1 | One-clock pulse at the timer rate |

## Verification
The checker assumes that `access_start` is a pulse of one clock. It also assumes that the selects it reads at the start clock are the ones the cycle logic latches. Its tick-period check resumes only after a full tick interval has passed with no configuration write, because the first interval after a change is allowed to be irregular. The stimulus drives `access_start` for exactly one clock each time. It changes the configuration either while idle or in the middle of a cycle, and always lets at least one full interval pass before timer periods are measured.

// File: rtl/bct_pkg.sv
package bct_pkg;
   typedef logic [1:0] div_sel_t;

   // CPU cycle length in units; the anomalous variant stretches the slow settings
   function automatic int unsigned cyc_units(input div_sel_t s, input bit anomaly);
      case (s)
         2'd0:    return 1;
         2'd1:    return 2;
         2'd2:    return anomaly ? 5 : 4;
         default: return anomaly ? 10 : 8;
      endcase
   endfunction

   // Timer period in units: always a clean power of two
   function automatic int unsigned tick_units(input div_sel_t s);
      return 32'd1 << s;
   endfunction
endpackage

// File: rtl/bct_cfg_reg.sv
module bct_cfg_reg #(
   parameter int CFG_W   = 8,
   parameter int EXT_LSB = 4,
   parameter int INT_LSB = 6
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 we,
   input  logic [CFG_W-1:0]     wdata,
   output bct_pkg::div_sel_t    ext_sel,
   output bct_pkg::div_sel_t    int_sel
);
   if (EXT_LSB + 1 >= CFG_W || INT_LSB + 1 >= CFG_W) begin : g_bad_pos
      $error("bct_cfg_reg: select field lies outside the configuration byte");
   end
   if (EXT_LSB == INT_LSB) begin : g_overlap
      $error("bct_cfg_reg: select fields overlap");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ext_sel <= '0;
         int_sel <= '0;
      end else if (we) begin
         ext_sel <= wdata[EXT_LSB +: 2];
         int_sel <= wdata[INT_LSB +: 2];
      end
   end
endmodule

// File: rtl/bct_cycle_gen.sv
module bct_cycle_gen #(
   parameter int UNIT_CLKS = 24,
   parameter bit ANOMALY   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              acc_type,
   input  bct_pkg::div_sel_t ext_sel,
   input  bct_pkg::div_sel_t int_sel,
   output logic              done
);
   localparam int MAX_LEN = UNIT_CLKS * 10;
   localparam int CNT_W   = $clog2(MAX_LEN);

   if (UNIT_CLKS < 2) begin : g_bad_unit
      $error("bct_cycle_gen: a unit must span at least two clocks");
   end

   logic [CNT_W-1:0] len_lut [4];
   for (genvar g = 0; g < 4; g++) begin : g_lut
      assign len_lut[g] = CNT_W'(UNIT_CLKS * bct_pkg::cyc_units(bct_pkg::div_sel_t'(g), ANOMALY));
   end

   bct_pkg::div_sel_t sel;
   logic [CNT_W-1:0]  len;
   logic              busy;
   logic [CNT_W-1:0]  remain;
   logic              accept;

   assign sel    = acc_type ? ext_sel : int_sel;
   assign len    = len_lut[sel];
   assign done   = busy && (remain == '0);
   assign accept = start && (!busy || done);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (accept) begin
         busy   <= 1'b1;
         remain <= len - CNT_W'(2);
      end else if (busy) begin
         if (done) busy <= 1'b0;
         else      remain <= remain - CNT_W'(1);
      end
   end
endmodule

// File: rtl/bct_tick_gen.sv
module bct_tick_gen #(
   parameter int UNIT_CLKS = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  bct_pkg::div_sel_t int_sel,
   output logic              tick
);
   localparam int MAX_PER = UNIT_CLKS * 8;
   localparam int TW      = $clog2(MAX_PER);

   if (UNIT_CLKS < 2) begin : g_bad_unit
      $error("bct_tick_gen: a unit must span at least two clocks");
   end

   logic [TW-1:0] last_lut [4];
   for (genvar g = 0; g < 4; g++) begin : g_lut
      assign last_lut[g] = TW'(UNIT_CLKS * bct_pkg::tick_units(bct_pkg::div_sel_t'(g)) - 1);
   end

   logic [TW-1:0] tcnt;
   assign tick = (tcnt >= last_lut[int_sel]);

   always_ff @(posedge clk) begin
      if (rst)       tcnt <= '0;
      else if (tick) tcnt <= '0;
      else           tcnt <= tcnt + TW'(1);
   end
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer #(
   parameter int BASE_DIV = 12,
   parameter bit ANOMALY  = 1'b1,
   parameter int CFG_W    = 8,
   parameter int EXT_LSB  = 4,
   parameter int INT_LSB  = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             access_start,
   input  logic             access_type,
   output logic             cycle_done,
   output logic             timer_tick
);
   localparam int UNIT_CLKS = 2 * BASE_DIV;

   if (BASE_DIV < 1) begin : g_bad_div
      $error("bus_cycle_timer: BASE_DIV must be positive");
   end

   bct_pkg::div_sel_t ext_sel;
   bct_pkg::div_sel_t int_sel;

   bct_cfg_reg #(.CFG_W(CFG_W), .EXT_LSB(EXT_LSB), .INT_LSB(INT_LSB)) u_cfg (
      .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
      .ext_sel(ext_sel), .int_sel(int_sel)
   );

   bct_cycle_gen #(.UNIT_CLKS(UNIT_CLKS), .ANOMALY(ANOMALY)) u_cyc (
      .clk(clk), .rst(rst), .start(access_start), .acc_type(access_type),
      .ext_sel(ext_sel), .int_sel(int_sel), .done(cycle_done)
   );

   bct_tick_gen #(.UNIT_CLKS(UNIT_CLKS)) u_tick (
      .clk(clk), .rst(rst), .int_sel(int_sel), .tick(timer_tick)
   );
endmodule

// File: rtl/bus_cycle_timer_chk.sv
module bus_cycle_timer_chk #(
   parameter int UNIT_CLKS = 24,
   parameter bit ANOMALY   = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              cfg_we,
   input logic              access_start,
   input logic              access_type,
   input logic              cycle_done,
   input logic              timer_tick,
   input bct_pkg::div_sel_t ext_sel,
   input bct_pkg::div_sel_t int_sel
);
   int unsigned ck_len;
   int unsigned ck_el;
   logic        ck_busy;
   int unsigned tk_gap;
   logic        tk_valid;
   int unsigned new_len;
   int unsigned tk_per;

   assign new_len = UNIT_CLKS * bct_pkg::cyc_units(access_type ? ext_sel : int_sel, ANOMALY);
   assign tk_per  = UNIT_CLKS * bct_pkg::tick_units(int_sel);

   always_ff @(posedge clk) begin
      if (rst) begin
         ck_busy <= 1'b0;
         ck_len  <= 0;
         ck_el   <= 0;
      end else if (access_start && (!ck_busy || cycle_done)) begin
         ck_busy <= 1'b1;
         ck_len  <= new_len;
         ck_el   <= 1;
      end else if (ck_busy) begin
         if (cycle_done) ck_busy <= 1'b0;
         else            ck_el   <= ck_el + 1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tk_gap   <= 0;
         tk_valid <= 1'b0;
      end else begin
         tk_gap   <= timer_tick ? 0 : tk_gap + 1;
         tk_valid <= cfg_we ? 1'b0 : (timer_tick ? 1'b1 : tk_valid);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst && cycle_done)
         a_r6_idle_quiet: assert (ck_busy) else $error("cycle_done without a pending cycle");
   end

   a_r2_len_match: assert property (@(posedge clk) disable iff (rst)
      cycle_done |-> (ck_el == ck_len - 1));

   a_r4_done_on_last: assert property (@(posedge clk) disable iff (rst)
      (ck_busy && ck_el == ck_len - 1) |-> cycle_done);

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
      cycle_done |=> !cycle_done);

   a_r8_tick_period: assert property (@(posedge clk) disable iff (rst)
      (timer_tick && tk_valid && !cfg_we) |-> (tk_gap + 1 == tk_per));
endmodule

bind bus_cycle_timer bus_cycle_timer_chk #(.UNIT_CLKS(UNIT_CLKS), .ANOMALY(ANOMALY)) u_chk (
   .clk(clk), .rst(rst), .cfg_we(cfg_we), .access_start(access_start),
   .access_type(access_type), .cycle_done(cycle_done), .timer_tick(timer_tick),
   .ext_sel(ext_sel), .int_sel(int_sel)
);

// File: tb/bus_cycle_timer_test.sv
module bus_cycle_timer_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       access_start = 1'b0;
   logic       access_type = 1'b0;
   logic       cycle_done;
   logic       timer_tick;

   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc = 0;
   int    last_exp = 0;
   int    exp_q[$];
   string cur_req = "R1";
   bit    finished = 1'b0;

   localparam int LEN [4] = '{24, 48, 120, 240};

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   bus_cycle_timer uut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .access_start(access_start), .access_type(access_type),
      .cycle_done(cycle_done), .timer_tick(timer_tick)
   );

   // monitor: compares cycle_done against the scoreboard queue
   always @(negedge clk) begin
      if (!rst) begin
         if (exp_q.size() > 0 && exp_q[0] == cyc) begin
            n_chk++;
            if (cycle_done !== 1'b1) begin
               n_bad++;
               $display("FAIL %s: cycle_done=%b expected 1 at clock %0d", cur_req, cycle_done, cyc);
            end
            void'(exp_q.pop_front());
         end else if (cycle_done !== 1'b0) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s: cycle_done=%b expected 0 at clock %0d", cur_req, cycle_done, cyc);
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [7:0] v);
      cfg_we = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic start_acc(input bit t, input int len);
      access_start = 1'b1;
      access_type = t;
      last_exp = cyc + len - 1;
      exp_q.push_back(last_exp);
      @(negedge clk);
      access_start = 1'b0;
   endtask

   task automatic wait_done();
      while (cyc < last_exp) @(negedge clk);
   endtask

   task automatic acc(input bit t, input int len);
      start_acc(t, len);
      wait_done();
      @(negedge clk);
   endtask

   task automatic check_ticks(input string req, input int per, input int n);
      int t0;
      do @(negedge clk); while (!timer_tick);
      t0 = cyc;
      for (int i = 0; i < n; i++) begin
         do @(negedge clk); while (!timer_tick);
         check(req, cyc - t0, per);
         t0 = cyc;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int k;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs quiet in reset
      check("R1", cycle_done, 0);
      check("R1", timer_tick, 0);
      k = cyc;
      rst = 1'b0;
      // R1: first tick on the 24th clock after release
      while (!timer_tick && cyc < k + 100) @(negedge clk);
      check("R1", cyc, k + 23);
      @(negedge clk);

      // R1: both selects clear after reset
      cur_req = "R1";
      acc(1'b0, 24);
      acc(1'b1, 24);

      // R2 / R3: internal select in bits 7:6
      for (int s = 1; s < 4; s++) begin
         cur_req = "R2";
         wr_cfg(8'(s << 6));
         acc(1'b0, LEN[s]);
         cur_req = "R3";
         acc(1'b1, 24);
      end
      // R2 / R3: external select in bits 5:4
      for (int s = 1; s < 4; s++) begin
         cur_req = "R2";
         wr_cfg(8'(s << 4));
         acc(1'b1, LEN[s]);
         cur_req = "R3";
         acc(1'b0, 24);
      end
      // R3: mixed selects
      cur_req = "R3";
      wr_cfg(8'h60);
      acc(1'b1, 120);
      acc(1'b0, 48);

      // R5: write during a cycle affects only the next one
      cur_req = "R5";
      wr_cfg(8'h00);
      start_acc(1'b1, 24);
      repeat (3) @(negedge clk);
      wr_cfg(8'h30);
      wait_done();
      @(negedge clk);
      acc(1'b1, 240);

      // R6: start during a running cycle is ignored; idle stays quiet
      cur_req = "R6";
      wr_cfg(8'h00);
      start_acc(1'b0, 24);
      repeat (4) @(negedge clk);
      access_start = 1'b1;
      @(negedge clk);
      access_start = 1'b0;
      wait_done();
      repeat (30) @(negedge clk);

      // R7 / R4: back-to-back starts on the done clock
      cur_req = "R7";
      wr_cfg(8'h40);
      start_acc(1'b0, 48);
      wait_done();
      start_acc(1'b1, 24);
      wait_done();
      start_acc(1'b0, 48);
      wait_done();
      @(negedge clk);

      // R8: timer period for each internal select
      cur_req = "R8";
      for (int s = 0; s < 4; s++) begin
         wr_cfg(8'(s << 6));
         check_ticks("R8", 24 << s, 3);
      end
      // R8: timer unaffected by a running access
      wr_cfg(8'h40);
      start_acc(1'b1, 24);
      check_ticks("R8", 48, 2);
      repeat (50) @(negedge clk);
      check("R6", exp_q.size(), 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule